// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Controller

This block lets any core in a small multiprocessor interrupt any other core and pass it a 16-bit message. Each core has an 8-byte window on a simple 32-bit register bus. The window holds a control word, which the core writes to send or to acknowledge, and a status word, which reports the last message delivered to that core. The block drives one level-sensitive interrupt line per core.

A send is a single control write. In that same clock edge, the target's status register is loaded with a pending flag, the sender's index and the payload. The target's line stays high until that core acknowledges by writing its own control word with the acknowledge bit set. The number of cores is a parameter from 1 to 4.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: Address bits [4:3] select the core window and bit 2 selects the register (0 = control, 1 = status). Bits [1:0] are ignored. A window at or above the configured core count reads as zero, and writes to it have no effect.
- R2: A write to a core's control register stores the whole 32-bit word, and a read returns that word unchanged. The control fields are: bit 31 acknowledge, bit 30 send, bits [29:16] destination core, bits [15:0] payload.
- R3: Reads of a status register return its present contents. The status fields are: bit 31 always 0, bit 30 pending, bits [29:16] sender index, bits [15:0] payload.
- R4: A control write with the send bit set loads the destination's status with pending = 1, the writing core's index and the written bits [15:0]. The destination's interrupt line is high from the next cycle.
- R5: A control write with the acknowledge bit set clears the writing core's pending flag and its line. The sender and payload fields are kept.
- R6: Writes to a status register change no state.
- R7: When send and acknowledge are both set in one write, the send is applied first and the acknowledge second. A core that sends to itself in this way ends with the new sender and payload fields and with pending = 0.
- R8: A send whose destination is at or above the core count changes no status register and raises no line.
- R9: An interrupt line stays high until its core acknowledges. A new message to a core that is already pending overwrites the sender and payload fields and leaves the line high.
- R10: A synchronous active-high reset clears every control and status register and drops every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address inside the block |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | NCORES | Level interrupt line per core |

## Verification
Delivery and acknowledge can hit the same status register in one cycle. The bench provokes this with a single control write that sets both bits and names the writer as its own destination. It also writes both bits with a different destination, so that the delivery and the acknowledge land on separate cores. The expected status and line values come from a bench model that applies the send before the acknowledge. The read and line checks after each write are compared against that model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int MAX_CORES = 4;
    localparam int ID_W      = 14;
    localparam int PAY_W     = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;

    typedef enum logic { REG_CTRL = 1'b0, REG_STAT = 1'b1 } reg_sel_e;

    typedef struct packed {
        logic             ack;
        logic             send;
        logic [ID_W-1:0]  dst;
        logic [PAY_W-1:0] payload;
    } ctrl_word_t;

    typedef struct packed {
        logic             rsvd;
        logic             pending;
        logic [ID_W-1:0]  src;
        logic [PAY_W-1:0] payload;
    } stat_word_t;

    typedef struct packed {
        logic            wr_ctrl;
        logic [ID_W-1:0] src;
        ctrl_word_t      word;
    } cmd_t;

    function automatic stat_word_t deliver(input logic [ID_W-1:0] src,
                                           input logic [PAY_W-1:0] pay);
        stat_word_t s;
        s.rsvd    = 1'b0;
        s.pending = 1'b1;
        s.src     = src;
        s.payload = pay;
        return s;
    endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd,
    output logic [ID_W-1:0]   win,
    output reg_sel_e          rsel,
    output logic              win_ok
);
    always_comb begin
        win          = {{(ID_W-2){1'b0}}, addr[4:3]};
        rsel         = reg_sel_e'(addr[2]);
        win_ok       = win < ID_W'(NCORES);
        cmd.wr_ctrl  = we && win_ok && (rsel == REG_CTRL);
        cmd.src      = win;
        cmd.word     = ctrl_word_t'(wdata);
    end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
    import ipi_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    output logic [DATA_W-1:0] ctrl_q,
    output stat_word_t        stat_q,
    output logic              irq
);
    logic own_wr, gen_hit, ack_hit;
    stat_word_t stat_d;

    always_comb begin
        own_wr  = cmd.wr_ctrl && (cmd.src == ID_W'(IDX));
        gen_hit = cmd.wr_ctrl && cmd.word.send && (cmd.word.dst == ID_W'(IDX));
        ack_hit = own_wr && cmd.word.ack;
        stat_d  = stat_q;
        if (gen_hit) stat_d = deliver(cmd.src, cmd.word.payload);
        if (ack_hit) stat_d.pending = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (own_wr) ctrl_q <= DATA_W'(cmd.word);
            stat_q <= stat_d;
        end
    end

    assign irq = stat_q.pending;

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        own_wr |=> ctrl_q == $past(DATA_W'(cmd.word)));
    // R4
    gen_deliver_chk: assert property (@(posedge clk) disable iff (rst)
        gen_hit && !ack_hit |=> irq && stat_q.src == $past(cmd.src)
                               && stat_q.payload == $past(cmd.word.payload));
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack_hit && !gen_hit |=> !irq && stat_q.src == $past(stat_q.src)
                               && stat_q.payload == $past(stat_q.payload));
    // R7
    both_self_chk: assert property (@(posedge clk) disable iff (rst)
        ack_hit && gen_hit |=> !irq && stat_q.src == $past(cmd.src));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_hit && !ack_hit |=> $stable(stat_q));
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
    import ipi_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCORES-1:0] irq_out
);
    cmd_t            cmd;
    logic [ID_W-1:0] win;
    reg_sel_e        rsel;
    logic            win_ok;

    logic [DATA_W-1:0] ctrl_arr [NCORES];
    stat_word_t        stat_arr [NCORES];

    ipi_decode #(.NCORES(NCORES)) u_dec (
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .cmd(cmd), .win(win), .rsel(rsel), .win_ok(win_ok)
    );

    for (genvar g = 0; g < NCORES; g++) begin : g_slot
        ipi_slot #(.IDX(g)) u_slot (
            .clk(clk), .rst(rst), .cmd(cmd),
            .ctrl_q(ctrl_arr[g]), .stat_q(stat_arr[g]), .irq(irq_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (win_ok && win == ID_W'(i))
                bus_rdata = (rsel == REG_CTRL) ? ctrl_arr[i] : DATA_W'(stat_arr[i]);
        end
    end

    // R8
    bad_dst_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.wr_ctrl && cmd.word.send && !cmd.word.ack
        && cmd.word.dst >= ID_W'(NCORES) |=> $stable(irq_out));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> irq_out == '0);
    // R6
    stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we && rsel == REG_STAT |=> $stable(irq_out));
endmodule

// File: tb/test_ipi_mailbox_ctrl.sv
module test_ipi_mailbox_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic we_b = 1'b0, we_s = 1'b0;
    logic [31:0] rdata_b, rdata_s;
    logic [3:0]  irq_b;
    logic [1:0]  irq_s;

    always #2 clk = ~clk;

    ipi_mailbox_ctrl #(.NCORES(4)) i_ipi_mailbox_ctrl (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_b),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_out(irq_b));
    ipi_mailbox_ctrl #(.NCORES(2)) i_small (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_s),
        .bus_wdata(wdata), .bus_rdata(rdata_s), .irq_out(irq_s));

    typedef struct {
        int          dut;
        logic        is_irq;
        logic [4:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    int compared = 0, mismatched = 0;
    bit finished = 0;
    int ncore [2] = '{4, 2};
    logic [31:0] ctrl_m [2][4];
    logic [31:0] stat_m [2][4];

    task automatic model_reset();
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 4; c++) begin
                ctrl_m[d][c] = '0; stat_m[d][c] = '0;
            end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    // driver: bus write plus model update from the requirements
    task automatic wr(int d, logic [4:0] a, logic [31:0] v);
        int c, dst;
        @(negedge clk);
        addr = a; wdata = v;
        if (d == 0) we_b = 1'b1; else we_s = 1'b1;
        @(negedge clk);
        we_b = 1'b0; we_s = 1'b0;
        c = int'(a[4:3]);
        if (c < ncore[d] && a[2] == 1'b0) begin
            ctrl_m[d][c] = v;
            if (v[30]) begin
                dst = int'(v[29:16]);
                if (dst < ncore[d]) stat_m[d][dst] = {2'b01, 14'(c), v[15:0]};
            end
            if (v[31]) stat_m[d][c][30] = 1'b0;
        end
    endtask

    function automatic logic [31:0] mk(bit ack, bit snd, int dst, logic [15:0] p);
        return {ack, snd, 14'(dst), p};
    endfunction

    task automatic expect_all(int d, string tag);
        item_t it;
        logic [31:0] iv;
        iv = '0;
        for (int c = 0; c < 4; c++) begin
            it.dut = d; it.is_irq = 0; it.tag = tag;
            it.a = {2'(c), 3'b000}; it.exp = (c < ncore[d]) ? ctrl_m[d][c] : '0; sbq.push_back(it);
            it.a = {2'(c), 3'b100}; it.exp = (c < ncore[d]) ? stat_m[d][c] : '0; sbq.push_back(it);
            if (c < ncore[d]) iv[c] = stat_m[d][c][30];
        end
        it.is_irq = 1; it.a = '0; it.exp = iv; sbq.push_back(it);
    endtask

    // monitor: pops expected items and compares against live outputs
    task automatic drain();
        item_t it;
        logic [31:0] act;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            @(negedge clk);
            addr = it.a; we_b = 1'b0; we_s = 1'b0;
            #1;
            if (it.is_irq) act = (it.dut == 0) ? 32'(irq_b) : 32'(irq_s);
            else           act = (it.dut == 0) ? rdata_b : rdata_s;
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s dut%0d addr=%h irq=%0d actual=%h expected=%h",
                         it.tag, it.dut, it.a, it.is_irq, act, it.exp);
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #80000;
        compared++; mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();
        expect_all(0, "R10 reset state"); expect_all(1, "R10 reset state small"); drain();

        wr(0, 5'h00, mk(0, 1, 2, 16'hBEEF));           // core0 -> core2
        expect_all(0, "R4 R2 send 0->2"); drain();

        wr(0, 5'h08, mk(0, 1, 2, 16'h1234));           // core1 -> core2 while pending
        expect_all(0, "R9 overwrite pending"); drain();

        wr(0, 5'h14, 32'hFFFF_FFFF);                   // status write to core2
        wr(0, 5'h04, 32'hC000_5555);                   // status write to core0
        expect_all(0, "R6 status write ignored R3"); drain();

        wr(0, 5'h10, mk(1, 0, 0, 16'h0000));           // core2 acknowledges
        expect_all(0, "R5 ack keeps fields"); drain();

        wr(0, 5'h18, mk(1, 1, 3, 16'h55AA));           // core3 self send + ack
        expect_all(0, "R7 self send and ack"); drain();

        wr(0, 5'h08, mk(0, 1, 5, 16'h7777));           // core1 -> core5 invalid
        wr(0, 5'h08, mk(0, 1, 14'h3FFF, 16'h7778));
        expect_all(0, "R8 bad destination"); drain();

        wr(0, 5'h03, mk(0, 1, 1, 16'hA5A5));           // low addr bits ignored
        expect_all(0, "R1 low bits ignored"); drain();

        wr(0, 5'h08, mk(1, 1, 0, 16'h0F0F));           // core1 acks self, sends to 0
        expect_all(0, "R7 send and ack on two cores"); drain();

        wr(0, 5'h10, mk(0, 1, 3, 16'h1111));
        expect_all(0, "R9 line held"); drain();

        wr(1, 5'h18, mk(0, 1, 0, 16'h9999));           // window 3 absent in small
        expect_all(1, "R1 absent window"); drain();
        wr(1, 5'h08, mk(0, 1, 0, 16'h4242));
        wr(1, 5'h00, mk(0, 1, 3, 16'h4343));
        expect_all(1, "R4 R8 small instance"); drain();

        do_reset();
        expect_all(0, "R10 reset mid run"); expect_all(1, "R10 reset mid run small"); drain();

        finish_run();
    end
endmodule